// File: doc/BRIEF.md
# Two-Port Banked L1 Load Front End

This block is the bank-arbitration stage of a banked level-one data cache that two load requesters share, for example two hardware threads on one core. A 64-byte line is split into sixteen 4-byte banks, and the bank a load uses is chosen by the word offset inside the line. Each bank can serve one read per cycle. When the two requesters target different banks, both are served in the same cycle. When they target the same bank, one is served and the other is held back. Every access is treated as a hit, so the block never misses and never writes.

Each requester has a load port with valid/ready flow control. The requester raises valid with an address and must keep valid high and the address unchanged until it sees ready. A transfer happens on a cycle where valid and ready are both high. Ready is produced in the same cycle from both requests, so a port can sustain one load per cycle when it is not stalled. The read response appears exactly one cycle after the transfer, on a return pulse with its data. The response has no back-pressure. The data array is modelled as preloaded contents computed from the word address. A per-port counter of stalled cycles makes the cost of bank collisions visible.

Top module: `cbank_l1_front`

## Requirements
- R1: The bank of a byte address is address bits [5:2], giving 16 banks of 4 bytes. When both ports are valid and their banks differ, both ready outputs are high in that cycle.
- R2: When both ports are valid and their banks are equal, exactly one ready is high. This includes addresses that differ by a multiple of 64 bytes.
- R3: Collisions are settled by alternating priority. After reset, port 0 wins the first collision. After each collision, the port that lost it wins the next one.
- R4: A port that is valid while the other port is idle gets ready in the same cycle. Ready is low whenever its own valid is low.
- R5: A transfer on a port raises that port's return valid in the next cycle, and only then.
- R6: Returned data for byte address A is W shifted right by 8*A[1:0]. W is a 32-bit word whose low half is the word index A[14:2], zero-extended to 16 bits, and whose high half is the bitwise inverse of that low half.
- R7: Each port's stall counter increments by one in every cycle in which that port is valid and not ready, and holds otherwise.
- R8: Back-to-back loads from one port to the same bank complete at one per cycle while the other port is idle.
- R9: Reset clears the return valids and the stall counters, and gives priority to port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_valid | input | 1 | Port 0 load request valid |
| p0_ready | output | 1 | Port 0 load accepted this cycle |
| p0_addr | input | 15 | Port 0 byte address |
| p1_valid | input | 1 | Port 1 load request valid |
| p1_ready | output | 1 | Port 1 load accepted this cycle |
| p1_addr | input | 15 | Port 1 byte address |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | 32 | Port 0 read data |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | 32 | Port 1 read data |
| p0_stalls | output | CNT_W | Port 0 stalled-cycle count |
| p1_stalls | output | CNT_W | Port 1 stalled-cycle count |

## Verification
Some properties hold cycle by cycle, and the assertions check them on every cycle: a collision never grants both ports, different banks or a lone request always get ready, the return pulse follows each transfer by one cycle, each stall bumps the counter, and a port that lost a collision wins a back-to-back repeat. Other behaviour needs a chosen sequence of addresses, so only the bench scenarios can show it. These are the data values returned for aligned and unaligned addresses, the priority order after reset and after a mid-run reset, and collisions at the first and last bank.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
  localparam int LINE_BYTES = 64;
  localparam int WORD_BYTES = 4;
  localparam int SETS       = 64;
  localparam int WAYS       = 8;
  localparam int NPORTS     = 2;

  localparam int NUM_BANKS  = LINE_BYTES / WORD_BYTES;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int LINE_W     = $clog2(LINE_BYTES);
  localparam int CAP_BYTES  = SETS * WAYS * LINE_BYTES;
  localparam int ADDR_W     = $clog2(CAP_BYTES);
  localparam int ROW_W      = ADDR_W - LINE_W;
  localparam int WIDX_W     = ADDR_W - OFF_W;
  localparam int DATA_W     = 8 * WORD_BYTES;
  localparam int HALF_W     = DATA_W / 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DATA_W-1:0] data_t;

  // Preloaded contents of the array: low half carries the word index,
  // high half its inverse.
  function automatic data_t fill_word(input logic [WIDX_W-1:0] widx);
    logic [HALF_W-1:0] lo;
    lo = HALF_W'(widx);
    return {~lo, lo};
  endfunction

  function automatic bank_t bank_of(input addr_t a);
    return a[LINE_W-1:OFF_W];
  endfunction

  function automatic row_t row_of(input addr_t a);
    return a[ADDR_W-1:LINE_W];
  endfunction
endpackage

// File: rtl/cbank_arb.sv
module cbank_arb
  import cbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req,
  input  bank_t             bank0,
  input  bank_t             bank1,
  output logic [NPORTS-1:0] grant
);
  logic prio_q;   // port that wins the next collision
  logic clash;

  always_comb begin
    clash = req[0] && req[1] && (bank0 == bank1);
    grant = req;
    if (clash) grant = prio_q ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prio_q <= 1'b0;
    else if (clash) prio_q <= ~prio_q;
  end
endmodule

// File: rtl/cbank_slice.sv
module cbank_slice
  import cbank_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] hit,
  input  row_t              row0,
  input  row_t              row1,
  output data_t             q
);
  localparam bank_t MY_BANK = bank_t'(BANK_ID);
  row_t sel_row;

  assign sel_row = hit[1] ? row1 : row0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (|hit) q <= fill_word({sel_row, MY_BANK});
  end
endmodule

// File: rtl/cbank_rport.sv
module cbank_rport
  import cbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  grant,
  input  bank_t bank,
  input  off_t  off,
  input  data_t slice_q [NUM_BANKS],
  output logic  rvalid,
  output data_t rdata
);
  bank_t bank_q;
  off_t  off_q;
  data_t word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      bank_q <= '0;
      off_q  <= '0;
    end else begin
      rvalid <= grant;
      if (grant) begin
        bank_q <= bank;
        off_q  <= off;
      end
    end
  end

  assign word  = slice_q[bank_q];
  assign rdata = word >> {off_q, 3'b000};
endmodule

// File: rtl/cbank_stall_ctr.sv
module cbank_stall_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lose,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (lose) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbank_l1_front.sv
module cbank_l1_front
  import cbank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  output logic              p0_ready,
  input  logic [14:0]       p0_addr,
  input  logic              p1_valid,
  output logic              p1_ready,
  input  logic [14:0]       p1_addr,
  output logic              p0_rvalid,
  output logic [31:0]       p0_rdata,
  output logic              p1_rvalid,
  output logic [31:0]       p1_rdata,
  output logic [CNT_W-1:0]  p0_stalls,
  output logic [CNT_W-1:0]  p1_stalls
);
  logic [NPORTS-1:0] req, grant, rv;
  addr_t             addr [NPORTS];
  bank_t             bank [NPORTS];
  data_t             rd   [NPORTS];
  data_t             slice_q [NUM_BANKS];
  logic [CNT_W-1:0]  cnt  [NPORTS];

  assign req     = {p1_valid, p0_valid};
  assign addr[0] = p0_addr;
  assign addr[1] = p1_addr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    assign bank[p] = bank_of(addr[p]);
  end

  cbank_arb arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .bank0 (bank[0]),
    .bank1 (bank[1]),
    .grant (grant)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NPORTS-1:0] hit;
    for (genvar p = 0; p < NPORTS; p++) begin : g_hit
      assign hit[p] = grant[p] && (bank[p] == bank_t'(b));
    end
    cbank_slice #(.BANK_ID(b)) slice_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .row0  (row_of(addr[0])),
      .row1  (row_of(addr[1])),
      .q     (slice_q[b])
    );
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    cbank_rport rport_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant[p]),
      .bank    (bank[p]),
      .off     (addr[p][OFF_W-1:0]),
      .slice_q (slice_q),
      .rvalid  (rv[p]),
      .rdata   (rd[p])
    );
    cbank_stall_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lose  (req[p] && !grant[p]),
      .cnt   (cnt[p])
    );
  end

  assign p0_ready  = grant[0];
  assign p1_ready  = grant[1];
  assign p0_rvalid = rv[0];
  assign p1_rvalid = rv[1];
  assign p0_rdata  = rd[0];
  assign p1_rdata  = rd[1];
  assign p0_stalls = cnt[0];
  assign p1_stalls = cnt[1];
endmodule

// File: rtl/cbank_l1_front_chk.sv
module cbank_l1_front_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             p0_valid,
  input logic             p0_ready,
  input logic [14:0]      p0_addr,
  input logic             p1_valid,
  input logic             p1_ready,
  input logic [14:0]      p1_addr,
  input logic             p0_rvalid,
  input logic [31:0]      p0_rdata,
  input logic             p1_rvalid,
  input logic [31:0]      p1_rdata,
  input logic [CNT_W-1:0] p0_stalls,
  input logic [CNT_W-1:0] p1_stalls
);
  logic same_bank, collide;
  assign same_bank = (p0_addr[5:2] == p1_addr[5:2]);
  assign collide   = p0_valid && p1_valid && same_bank;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $countones({p0_ready, p1_ready}) == 1); // R2

  AST_SPLIT_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p1_valid && !same_bank) |-> (p0_ready && p1_ready)); // R1

  AST_LONE_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p1_valid) |-> p0_ready); // R4

  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_valid |-> !p0_ready) and (!p1_valid |-> !p1_ready)); // R4

  AST_RET_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p0_ready) |=> p0_rvalid); // R5

  AST_NO_RET_P1: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_valid && p1_ready) |=> !p1_rvalid); // R5

  AST_STALL_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p0_ready) |=> p0_stalls == CNT_W'($past(p0_stalls) + 1'b1)); // R7

  AST_HOLD_P1: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_valid && !p1_ready) |=> $stable(p1_stalls)); // R7

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && p0_ready) ##1 collide |-> p1_ready); // R3
endmodule

bind cbank_l1_front cbank_l1_front_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/cbank_l1_front_tb_top.sv
module cbank_l1_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic        v0;
    logic [14:0] a0;
    logic        v1;
    logic [14:0] a1;
    logic        r0;
    logic        r1;
  } vec_t;

  // Expected ready values assume priority with port 0 right after reset.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 15'h0000, 1'b1, 15'h0004, 1'b1, 1'b1},  // R1 banks 0/1
    '{1'b1, 15'h0040, 1'b1, 15'h0080, 1'b1, 1'b0},  // R2 R3 bank 0, p0 wins
    '{1'b1, 15'h0102, 1'b1, 15'h0080, 1'b0, 1'b1},  // R3 p1 wins next
    '{1'b1, 15'h0102, 1'b0, 15'h0000, 1'b1, 1'b0},  // R4 held p0 alone
    '{1'b1, 15'h07FC, 1'b1, 15'h003C, 1'b1, 1'b0},  // R2 bank 15, p0 wins
    '{1'b1, 15'h013C, 1'b1, 15'h003C, 1'b0, 1'b1},  // R3 p1 wins
    '{1'b1, 15'h0009, 1'b1, 15'h000C, 1'b1, 1'b1},  // R1 banks 2/3
    '{1'b0, 15'h0000, 1'b0, 15'h0000, 1'b0, 1'b0},  // R4 idle
    '{1'b0, 15'h0000, 1'b1, 15'h7FFF, 1'b0, 1'b1},  // R4 R6 p1 alone, last byte
    '{1'b1, 15'h4444, 1'b1, 15'h0004, 1'b1, 1'b0}   // R2 bank 1, p0 wins
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              p0_valid = 1'b0, p1_valid = 1'b0;
  logic [14:0]       p0_addr = '0, p1_addr = '0;
  logic              p0_ready, p1_ready, p0_rvalid, p1_rvalid;
  logic [31:0]       p0_rdata, p1_rdata;
  logic [CNT_W-1:0]  p0_stalls, p1_stalls;

  int checks = 0;
  int fails  = 0;
  int exp_s0 = 0;
  int exp_s1 = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbank_l1_front #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_addr(p0_addr),
    .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_addr(p1_addr),
    .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
    .p0_stalls(p0_stalls), .p1_stalls(p1_stalls)
  );

  function automatic logic [31:0] model_data(input logic [14:0] a);
    logic [15:0] lo;
    lo = {3'b000, a[14:2]};
    return {~lo, lo} >> (8 * a[1:0]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check ready before the edge, results after it.
  task automatic step(input logic v0, input logic [14:0] a0, input logic v1,
                      input logic [14:0] a1, input logic er0, input logic er1);
    @(negedge clk);
    p0_valid = v0; p0_addr = a0; p1_valid = v1; p1_addr = a1;
    #1;
    check("R1/R2/R3/R4 p0_ready", 32'(p0_ready), 32'(er0));
    check("R1/R2/R3/R4 p1_ready", 32'(p1_ready), 32'(er1));
    if (v0 && !er0) exp_s0++;
    if (v1 && !er1) exp_s1++;
    @(posedge clk);
    #1;
    check("R5 p0_rvalid", 32'(p0_rvalid), 32'(v0 && er0));
    check("R5 p1_rvalid", 32'(p1_rvalid), 32'(v1 && er1));
    if (v0 && er0) check("R6 p0_rdata", p0_rdata, model_data(a0));
    if (v1 && er1) check("R6 p1_rdata", p1_rdata, model_data(a1));
    check("R7 p0_stalls", 32'(p0_stalls), 32'(exp_s0));
    check("R7 p1_stalls", 32'(p1_stalls), 32'(exp_s1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset p0_rvalid", 32'(p0_rvalid), 32'd0);
    check("R9 reset p1_rvalid", 32'(p1_rvalid), 32'd0);
    check("R9 reset p0_stalls", 32'(p0_stalls), 32'd0);
    check("R9 reset p1_stalls", 32'(p1_stalls), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      step(VEC[i].v0, VEC[i].a0, VEC[i].v1, VEC[i].a1, VEC[i].r0, VEC[i].r1);

    // R8: same-bank run on port 0 alone, one per cycle
    for (int k = 0; k < 4; k++)
      step(1'b1, 15'(16 + 64 * k), 1'b0, 15'h0000, 1'b1, 1'b0);

    // R2: addresses 64 apart collide; priority is now with port 1
    step(1'b1, 15'h0020, 1'b1, 15'h0060, 1'b0, 1'b1);
    // priority back to port 0; two collisions in a row alternate (R3)
    step(1'b1, 15'h0020, 1'b1, 15'h00A0, 1'b1, 1'b0);
    step(1'b1, 15'h00E0, 1'b1, 15'h00A0, 1'b0, 1'b1);
    step(1'b0, 15'h0000, 1'b0, 15'h0000, 1'b0, 1'b0);
    // leave priority with port 1, then reset mid-run
    step(1'b1, 15'h0030, 1'b1, 15'h0070, 1'b1, 1'b0);

    @(negedge clk);
    p0_valid = 1'b0; p1_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    exp_s0 = 0; exp_s1 = 0;
    check("R9 mid reset p0_stalls", 32'(p0_stalls), 32'd0);
    check("R9 mid reset p1_stalls", 32'(p1_stalls), 32'd0);
    check("R9 mid reset p0_rvalid", 32'(p0_rvalid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 R3: port 0 wins the first collision after reset
    step(1'b1, 15'h0014, 1'b1, 15'h0054, 1'b1, 1'b0);
    step(1'b1, 15'h0014, 1'b1, 15'h0054, 1'b0, 1'b1);
    step(1'b1, 15'h0015, 1'b0, 15'h0000, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule